// File: doc/BRIEF.md
# Super I/O configuration port

This block is the configuration front end of a legacy PC multi-function I/O controller. It sits on an 8-bit ISA-style port of two bytes: the even byte is an index register, the odd byte a data register. The index selects one of three configuration registers, and the data byte reads or writes it. The registers are function enable, function address and power/test. Reading the index byte right after reset returns an identification sequence, so software can detect the controller before it configures anything.

At reset the three registers are loaded from a table addressed by a 5-bit strap input. From the register contents the block continuously derives registered enables, base I/O addresses and interrupt numbers for a parallel port, two UARTs, a floppy controller and an IDE controller. Other logic uses these outputs to place those functions on the bus. A lock bit in the power register freezes the configuration until the next reset.

A small state machine tracks the identification sequence. Its states are `ID_MAGIC` (next index read returns 0x88), `ID_ZERO` (next index read returns 0x00) and `ID_ECHO` (index reads return the selected index). Its transitions are: `ID_MAGIC`→`ID_ZERO` on an index read, `ID_ZERO`→`ID_ECHO` on an index read, and any state→`ID_ECHO` on an index write. Reset returns it to `ID_MAGIC`. In every other case it holds its state.

Top module: `sio_cfg_port`

## Requirements
- R1: A strobe counts only when addr[15:1] equals PORT_BASE[15:1] (default base 0x398). Then addr[0]=0 reaches the index register and addr[0]=1 the data register. A read strobe off the base returns rdata 0x00, a write strobe off the base changes nothing, and rdata is 0x00 whenever no read strobe is present.
- R2: After reset the first index read returns 0x88, the second returns 0x00, and every later one returns the selected index. An index write moves straight to returning the selected index. Only index reads and index writes advance the sequence.
- R3: Synchronous active-high reset sets the selected index to 0 and loads enable/address/power from the strap table. Strap 0 gives 0x4F/0x10/0x00, strap 1 gives 0x4F/0x11/0x00, and strap 31 gives 0x00/0x10/0x02.
- R4: Index 0, 1 and 2 select enable, address and power. A data read returns that register in the cycle of the strobe, and a data write takes effect at that clock edge. With any other index, a data read returns 0x00 and a data write is ignored.
- R5: While power bit 6 is set, data writes to all three registers are ignored until reset. Reads and index writes still work.
- R6: par_en = enable bit 0, uart_en[n] = enable bit n+1, fdc_en = enable bit 3, ide_en = enable bit 6.
- R7: Address bits [1:0] set the parallel base: 0x378, 0x3BC, 0x278, or 0x000 for codes 0 to 3. The IRQ is 7 for code 1, 5 for code 2 and 0 for code 3. For code 0 the IRQ is 7 when power bit 3 is set and 5 when it is clear.
- R8: UART n uses address bits [2n+3:2n+2]. Code 0 gives 0x3F8 and code 1 gives 0x2F8. For code 2, address bits [7:6] = 0..3 pick 0x3E8, 0x338, 0x2E8 or 0x220. For code 3 they pick 0x2E8, 0x238, 0x2E0 or 0x228. The IRQ is 3 for odd codes and 4 for even codes.
- R9: The floppy base is 0x3F0, or 0x370 when enable bit 5 is set, and fdc_irq is 6. The IDE base is 0x1F0, or 0x170 when enable bit 7 is set. ide_irq is 14 and ide_base2 = ide_base + 0x206.
- R10: All derived outputs are registered. They show a register change one clock edge after the edge that wrote it, and they read zero while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 5 | Reset configuration select |
| addr | input | 16 | I/O address |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rd_en |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port base |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | UART enables |
| uart_base | output | 2x16 | UART bases |
| uart_irq | output | 2x4 | UART IRQs |
| fdc_en | output | 1 | Floppy enable |
| fdc_base | output | 16 | Floppy base |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | IDE enable |
| ide_base | output | 16 | IDE primary base |
| ide_base2 | output | 16 | IDE secondary base |
| ide_irq | output | 4 | IDE IRQ |

## Verification
Read data is combinational, so the bench compares rdata in the same cycle as the read strobe. A register write lands at the edge that samples the strobe. Every derived output lags that register by one more edge, so its new value is first visible two negedges after the strobe is driven. The reference model keeps its own registered copy of each derived output, computed from its register state before that edge's update, and compares every output shortly after each falling edge. Directed checks sample the derived outputs at the negedge right after a write edge, where the old value must still show, and again one cycle later, where the new value must show.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int IO_W     = 16;
    localparam int IRQ_W    = 4;
    localparam int NUM_UART = 2;
    localparam int STRAP_W  = 5;
    localparam logic [7:0] ID_BYTE = 8'h88;

    typedef enum logic [1:0] {ID_MAGIC, ID_ZERO, ID_ECHO} id_state_e;

    typedef struct packed {
        logic [7:0] fen;
        logic [7:0] fad;
        logic [7:0] pwr;
    } cfg_regs_t;

    function automatic cfg_regs_t strap_defaults(input logic [STRAP_W-1:0] s);
        cfg_regs_t r;
        if (s <= 5'd5)       r.fen = 8'h4F;
        else if (s <= 5'd11) r.fen = 8'h4B;
        else if (s <= 5'd15) r.fen = 8'h0F;
        else if (s <= 5'd19) r.fen = 8'h49;
        else if (s <= 5'd23) r.fen = 8'h07;
        else if (s <= 5'd29) r.fen = 8'h47;
        else if (s == 5'd30) r.fen = 8'h08;
        else                 r.fen = 8'h00;
        unique case (s)
            5'd3, 5'd14, 5'd22, 5'd27:               r.fad = 8'h39;
            5'd4, 5'd15, 5'd23, 5'd28:               r.fad = 8'h24;
            5'd5, 5'd29:                             r.fad = 8'h38;
            5'd6, 5'd16, 5'd19:                      r.fad = 8'h00;
            5'd7, 5'd8, 5'd17, 5'd18:                r.fad = 8'h01;
            5'd9:                                    r.fad = 8'h09;
            5'd10, 5'd11:                            r.fad = 8'h08;
            5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  r.fad = 8'h11;
            default:                                 r.fad = 8'h10;
        endcase
        r.pwr = (s == 5'd31) ? 8'h02 : 8'h00;
        return r;
    endfunction

    function automatic logic [IO_W-1:0] uart_base_of(input logic [1:0] code,
                                                     input logic [1:0] sel);
        logic [IO_W-1:0] b;
        unique case (code)
            2'd0: b = 16'h03F8;
            2'd1: b = 16'h02F8;
            2'd2: begin
                unique case (sel)
                    2'd0: b = 16'h03E8;
                    2'd1: b = 16'h0338;
                    2'd2: b = 16'h02E8;
                    default: b = 16'h0220;
                endcase
            end
            default: begin
                unique case (sel)
                    2'd0: b = 16'h02E8;
                    2'd1: b = 16'h0238;
                    2'd2: b = 16'h02E0;
                    default: b = 16'h0228;
                endcase
            end
        endcase
        return b;
    endfunction
endpackage

// File: rtl/sio_id_fsm.sv
module sio_id_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_rd,
    input  logic       idx_wr,
    input  logic [7:0] sel_idx,
    output logic [7:0] id_rdata
);
    id_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ID_MAGIC;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            state_d = ID_ECHO;
        end else if (idx_rd) begin
            unique case (state_q)
                ID_MAGIC: state_d = ID_ZERO;
                ID_ZERO:  state_d = ID_ECHO;
                default:  state_d = ID_ECHO;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ID_MAGIC: id_rdata = ID_BYTE;
            ID_ZERO:  id_rdata = 8'h00;
            default:  id_rdata = sel_idx;
        endcase
    end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap,
    input  logic               idx_wr,
    input  logic               dat_wr,
    input  logic [7:0]         wdata,
    output logic [7:0]         sel_idx,
    output cfg_regs_t          cfg,
    output logic [7:0]         dat_rdata
);
    localparam int LOCK_BIT = 6;
    logic locked;
    assign locked = cfg.pwr[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_idx <= 8'h00;
            cfg     <= strap_defaults(strap);
        end else begin
            if (idx_wr) sel_idx <= wdata;
            if (dat_wr && !locked) begin
                unique case (sel_idx)
                    8'd0: cfg.fen <= wdata;
                    8'd1: cfg.fad <= wdata;
                    8'd2: cfg.pwr <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel_idx)
            8'd0: dat_rdata = cfg.fen;
            8'd1: dat_rdata = cfg.fad;
            8'd2: dat_rdata = cfg.pwr;
            default: dat_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_cfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  cfg_regs_t                      cfg,
    output logic                           par_en,
    output logic [IO_W-1:0]                par_base,
    output logic [IRQ_W-1:0]               par_irq,
    output logic [NUM_UART-1:0]            uart_en,
    output logic [NUM_UART-1:0][IO_W-1:0]  uart_base,
    output logic [NUM_UART-1:0][IRQ_W-1:0] uart_irq,
    output logic                           fdc_en,
    output logic [IO_W-1:0]                fdc_base,
    output logic [IRQ_W-1:0]               fdc_irq,
    output logic                           ide_en,
    output logic [IO_W-1:0]                ide_base,
    output logic [IO_W-1:0]                ide_base2,
    output logic [IRQ_W-1:0]               ide_irq
);
    localparam logic [IO_W-1:0] IDE_ALT_OFS = 16'h0206;
    logic [IO_W-1:0]  par_base_d, ide_base_d;
    logic [IRQ_W-1:0] par_irq_d;

    always_comb begin
        unique case (cfg.fad[1:0])
            2'd0: begin par_base_d = 16'h0378; par_irq_d = cfg.pwr[3] ? 4'd7 : 4'd5; end
            2'd1: begin par_base_d = 16'h03BC; par_irq_d = 4'd7; end
            2'd2: begin par_base_d = 16'h0278; par_irq_d = 4'd5; end
            default: begin par_base_d = '0; par_irq_d = '0; end
        endcase
        ide_base_d = cfg.fen[7] ? 16'h0170 : 16'h01F0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_en <= 1'b0; par_base <= '0; par_irq <= '0;
            fdc_en <= 1'b0; fdc_base <= '0; fdc_irq <= '0;
            ide_en <= 1'b0; ide_base <= '0; ide_base2 <= '0; ide_irq <= '0;
        end else begin
            par_en    <= cfg.fen[0];
            par_base  <= par_base_d;
            par_irq   <= par_irq_d;
            fdc_en    <= cfg.fen[3];
            fdc_base  <= cfg.fen[5] ? 16'h0370 : 16'h03F0;
            fdc_irq   <= 4'd6;
            ide_en    <= cfg.fen[6];
            ide_base  <= ide_base_d;
            ide_base2 <= ide_base_d + IDE_ALT_OFS;
            ide_irq   <= 4'd14;
        end
    end

    for (genvar n = 0; n < NUM_UART; n++) begin : g_uart
        logic [1:0] code;
        assign code = cfg.fad[2*n+3 -: 2];
        always_ff @(posedge clk) begin
            if (rst) begin
                uart_en[n]   <= 1'b0;
                uart_base[n] <= '0;
                uart_irq[n]  <= '0;
            end else begin
                uart_en[n]   <= cfg.fen[n+1];
                uart_base[n] <= uart_base_of(code, cfg.fad[7:6]);
                uart_irq[n]  <= code[0] ? 4'd3 : 4'd4;
            end
        end
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     PORT_BASE = 16'h0398
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [STRAP_W-1:0]             strap,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           rd_en,
    input  logic                           wr_en,
    input  logic [7:0]                     wdata,
    output logic [7:0]                     rdata,
    output logic                           par_en,
    output logic [IO_W-1:0]                par_base,
    output logic [IRQ_W-1:0]               par_irq,
    output logic [NUM_UART-1:0]            uart_en,
    output logic [NUM_UART-1:0][IO_W-1:0]  uart_base,
    output logic [NUM_UART-1:0][IRQ_W-1:0] uart_irq,
    output logic                           fdc_en,
    output logic [IO_W-1:0]                fdc_base,
    output logic [IRQ_W-1:0]               fdc_irq,
    output logic                           ide_en,
    output logic [IO_W-1:0]                ide_base,
    output logic [IO_W-1:0]                ide_base2,
    output logic [IRQ_W-1:0]               ide_irq
);
    localparam logic [ADDR_W-1:0] BASE_A = PORT_BASE[ADDR_W-1:0];

    logic       hit, idx_rd, idx_wr, dat_wr;
    logic [7:0] sel_idx, id_rdata, dat_rdata;
    cfg_regs_t  cfg;

    assign hit    = (addr[ADDR_W-1:1] == BASE_A[ADDR_W-1:1]);
    assign idx_rd = rd_en && hit && !addr[0];
    assign idx_wr = wr_en && hit && !addr[0];
    assign dat_wr = wr_en && hit &&  addr[0];

    sio_id_fsm u_id (
        .clk(clk), .rst(rst), .idx_rd(idx_rd), .idx_wr(idx_wr),
        .sel_idx(sel_idx), .id_rdata(id_rdata)
    );

    sio_cfg_regs u_regs (
        .clk(clk), .rst(rst), .strap(strap), .idx_wr(idx_wr), .dat_wr(dat_wr),
        .wdata(wdata), .sel_idx(sel_idx), .cfg(cfg), .dat_rdata(dat_rdata)
    );

    sio_cfg_decode u_dec (
        .clk(clk), .rst(rst), .cfg(cfg),
        .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
        .uart_en(uart_en), .uart_base(uart_base), .uart_irq(uart_irq),
        .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
        .ide_en(ide_en), .ide_base(ide_base), .ide_base2(ide_base2), .ide_irq(ide_irq)
    );

    always_comb begin
        if (rd_en && hit) rdata = addr[0] ? dat_rdata : id_rdata;
        else              rdata = 8'h00;
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_BASE = 16'h0398
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        rdata,
    input logic [7:0]        sel_idx,
    input logic [23:0]       cfg_flat,
    input logic              fdc_en,
    input logic              ide_en,
    input logic [15:0]       ide_base,
    input logic [15:0]       ide_base2
);
    logic on_base;
    assign on_base = (addr[ADDR_W-1:1] == PORT_BASE[ADDR_W-1:1]);

    p_off_base_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !on_base) |-> (rdata == 8'h00));

    p_id_magic_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_en && on_base && !addr[0]) |-> (rdata == 8'h88));

    p_bad_index_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && on_base && addr[0] && sel_idx > 8'd2) |-> (rdata == 8'h00));

    p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_flat[6] && wr_en && on_base && addr[0]) |=> $stable(cfg_flat));

    p_ide_pair_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ide_base2 == ide_base + 16'h0206));

    p_decode_lag_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fdc_en == $past(cfg_flat[19]) && ide_en == $past(cfg_flat[22])));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rdata(rdata), .sel_idx(sel_idx), .cfg_flat(cfg), .fdc_en(fdc_en),
    .ide_en(ide_en), .ide_base(ide_base), .ide_base2(ide_base2)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  strap = 5'd1;
    logic [15:0] addr = 16'h0000;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        par_en, fdc_en, ide_en;
    logic [15:0] par_base, fdc_base, ide_base, ide_base2;
    logic [3:0]  par_irq, fdc_irq, ide_irq;
    logic [1:0]  uart_en;
    logic [1:0][15:0] uart_base;
    logic [1:0][3:0]  uart_irq;

    int n_chk = 0, n_fail = 0;
    bit started = 0, done = 0;

    always #5 clk = ~clk;

    sio_cfg_port dut_i (
        .clk(clk), .rst(rst), .strap(strap), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
        .uart_en(uart_en), .uart_base(uart_base), .uart_irq(uart_irq),
        .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
        .ide_en(ide_en), .ide_base(ide_base), .ide_base2(ide_base2), .ide_irq(ide_irq)
    );

    // behavioural reference state
    int m_step, m_idx, m_fen, m_fad, m_pwr;
    int e_par_en, e_par_base, e_par_irq, e_fdc_en, e_fdc_base, e_fdc_irq;
    int e_ide_en, e_ide_base, e_ide_base2, e_ide_irq;
    int e_u_en[2], e_u_base[2], e_u_irq[2];

    function automatic int uart_addr(int code, int sel);
        int lo[4] = '{'h3E8, 'h338, 'h2E8, 'h220};
        int hi[4] = '{'h2E8, 'h238, 'h2E0, 'h228};
        if (code == 0) return 'h3F8;
        if (code == 1) return 'h2F8;
        if (code == 2) return lo[sel];
        return hi[sel];
    endfunction

    function automatic bit on_port(int a);
        return (a == 'h398) || (a == 'h399);
    endfunction

    function automatic int exp_rdata();
        if (!rd_en || !on_port(addr)) return 0;
        if (addr[0] == 1'b0) begin
            if (m_step == 0) return 'h88;
            if (m_step == 1) return 0;
            return m_idx;
        end
        if (m_idx == 0) return m_fen;
        if (m_idx == 1) return m_fad;
        if (m_idx == 2) return m_pwr;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_step = 0; m_idx = 0;
            if (strap == 5'd0)      begin m_fen = 'h4F; m_fad = 'h10; m_pwr = 0; end
            else if (strap == 5'd1) begin m_fen = 'h4F; m_fad = 'h11; m_pwr = 0; end
            else                    begin m_fen = 'h00; m_fad = 'h10; m_pwr = 'h02; end
            e_par_en = 0; e_par_base = 0; e_par_irq = 0; e_fdc_en = 0; e_fdc_base = 0;
            e_fdc_irq = 0; e_ide_en = 0; e_ide_base = 0; e_ide_base2 = 0; e_ide_irq = 0;
            for (int u = 0; u < 2; u++) begin e_u_en[u] = 0; e_u_base[u] = 0; e_u_irq[u] = 0; end
            started = 1;
        end else begin
            int pc;
            pc = m_fad % 4;
            e_par_en   = m_fen % 2;
            e_par_base = (pc == 0) ? 'h378 : (pc == 1) ? 'h3BC : (pc == 2) ? 'h278 : 0;
            e_par_irq  = (pc == 1) ? 7 : (pc == 2) ? 5 : (pc == 3) ? 0 : (((m_pwr / 8) % 2) ? 7 : 5);
            for (int u = 0; u < 2; u++) begin
                int code;
                code = (m_fad >> (2 * u + 2)) % 4;
                e_u_en[u]   = (m_fen >> (u + 1)) % 2;
                e_u_base[u] = uart_addr(code, m_fad / 64);
                e_u_irq[u]  = (code % 2) ? 3 : 4;
            end
            e_fdc_en    = (m_fen / 8) % 2;
            e_fdc_base  = ((m_fen / 32) % 2) ? 'h370 : 'h3F0;
            e_fdc_irq   = 6;
            e_ide_en    = (m_fen / 64) % 2;
            e_ide_base  = (m_fen >= 128) ? 'h170 : 'h1F0;
            e_ide_base2 = e_ide_base + 'h206;
            e_ide_irq   = 14;
            if (on_port(addr) && !addr[0]) begin
                if (wr_en) begin m_step = 2; m_idx = wdata; end
                else if (rd_en && m_step < 2) m_step = m_step + 1;
            end
            if (on_port(addr) && addr[0] && wr_en && ((m_pwr / 64) % 2 == 0)) begin
                if (m_idx == 0) m_fen = wdata;
                else if (m_idx == 1) m_fad = wdata;
                else if (m_idx == 2) m_pwr = wdata;
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, shortly after each falling edge
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            chk(on_port(addr) ? (addr[0] ? "R4 rdata" : "R2 rdata") : "R1 rdata",
                int'(rdata), exp_rdata());
            chk("R6 par_en", int'(par_en), e_par_en);
            chk("R6 fdc_en", int'(fdc_en), e_fdc_en);
            chk("R6 ide_en", int'(ide_en), e_ide_en);
            chk("R7 par_base", int'(par_base), e_par_base);
            chk("R7 par_irq", int'(par_irq), e_par_irq);
            for (int u = 0; u < 2; u++) begin
                chk("R6 uart_en", int'(uart_en[u]), e_u_en[u]);
                chk("R8 uart_base", int'(uart_base[u]), e_u_base[u]);
                chk("R8 uart_irq", int'(uart_irq[u]), e_u_irq[u]);
            end
            chk("R9 fdc_base", int'(fdc_base), e_fdc_base);
            chk("R9 fdc_irq", int'(fdc_irq), e_fdc_irq);
            chk("R9 ide_base", int'(ide_base), e_ide_base);
            chk("R9 ide_base2", int'(ide_base2), e_ide_base2);
            chk("R9 ide_irq", int'(ide_irq), e_ide_irq);
        end
    end

    task automatic idle();
        @(negedge clk);
        rd_en = 0; wr_en = 0; addr = 16'h0000;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_en = 1; rd_en = 0; wdata = d;
        idle();
    endtask

    task automatic rd(input logic [15:0] a, input int exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1; wr_en = 0;
        #2 chk(req, int'(rdata), exp);
        idle();
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst = 1; strap = s; rd_en = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(5'd1);
        #2 chk("R10 reset outputs", int'(ide_en), 0);
        chk("R1 idle rdata", int'(rdata), 0);
        // R2 identification sequence, R3 strap 1 values
        rd(16'h0398, 'h88, "R2 first id");
        rd(16'h0398, 'h00, "R2 second id");
        rd(16'h0398, 'h00, "R2 echo");
        rd(16'h0399, 'h4F, "R3 strap1 enable");
        wr(16'h0398, 8'd1); rd(16'h0399, 'h11, "R3 strap1 address");
        wr(16'h0398, 8'd2); rd(16'h0399, 'h00, "R3 strap1 power");
        rd(16'h0398, 'h02, "R2 echo index");
        // R1 off-base accesses
        wr(16'h039A, 8'd0); wr(16'h039B, 8'hFF);
        rd(16'h0399, 'h00, "R1 off-base write ignored");
        rd(16'h039B, 'h00, "R1 off-base read");
        // R4 invalid index
        wr(16'h0398, 8'd5); wr(16'h0399, 8'hAA);
        rd(16'h0399, 'h00, "R4 bad index read");
        wr(16'h0398, 8'd0); rd(16'h0399, 'h4F, "R4 bad index write ignored");
        // R10 lag: write enable, old value seen one edge later, new one after the next
        wr(16'h0398, 8'd0);
        @(negedge clk); addr = 16'h0399; wr_en = 1; wdata = 8'h28;
        @(negedge clk); wr_en = 0; addr = 0;
        #2 chk("R10 still old", int'(ide_en), 1);
        @(negedge clk); #2 chk("R10 updated", int'(ide_en), 0);
        chk("R9 fdc alt base", int'(fdc_base), 'h370);
        // R6..R9 sweep across address codes and enables
        for (int v = 0; v < 256; v++) begin
            wr(16'h0398, 8'd1); wr(16'h0399, v[7:0]);
            wr(16'h0398, 8'd2); wr(16'h0399, (v % 3 == 0) ? 8'h08 : 8'h00);
            wr(16'h0398, 8'd0); wr(16'h0399, v[7:0] ^ 8'h5A);
        end
        // R3 strap 31, R2 index write skips the sequence
        do_reset(5'd31);
        wr(16'h0398, 8'd2);
        rd(16'h0398, 'h02, "R2 write skips id");
        rd(16'h0399, 'h02, "R3 strap31 power");
        wr(16'h0398, 8'd0); rd(16'h0399, 'h00, "R3 strap31 enable");
        // R5 lock
        wr(16'h0398, 8'd2); wr(16'h0399, 8'h48);
        wr(16'h0399, 8'h00); rd(16'h0399, 'h48, "R5 locked power");
        wr(16'h0398, 8'd1); wr(16'h0399, 8'hFF);
        rd(16'h0399, 'h10, "R5 locked address");
        rd(16'h0398, 'h01, "R5 index still writable");
        do_reset(5'd0);
        rd(16'h0398, 'h88, "R2 id after reset");
        wr(16'h0398, 8'd1); rd(16'h0399, 'h10, "R3 strap0 address");
        wr(16'h0399, 8'h33); rd(16'h0399, 'h33, "R5 unlocked after reset");
        repeat (3) idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule